// File: doc/BRIEF.md
# Two-Dimensional Parity Error Locator

This block checks a framed message of 7-bit text characters that arrive one byte per clock under a valid strobe. Every character byte carries an odd-parity bit in its top position, and a trailing check byte holds one odd-parity bit per bit position (column) over the whole frame. While the bytes stream in, the block tests each character's own parity (row parity), remembers the first failing character and how many characters failed, and folds every byte into a running column accumulator.

When the check byte has been taken, the block crosses the row and column results. Exactly one failing row together with exactly one failing column pins a single flipped bit to a character index and a bit index. A single failing column with no failing row places the flip in the check byte itself. Every other non-clean pattern is flagged as an error that cannot be located. The verdict appears with a one-cycle completion pulse and is held until the next frame begins. The block does not repair data and keeps no copy of the message.

Top module: `parity_locator`

## Requirements
- R1: While reset is asserted and after it is released, done, error_detected, single_error, err_byte_idx and err_bit_idx are all 0, and the first byte accepted after reset is treated as character index 0.
- R2: For a frame with no corrupted bit, done is 1 in the cycle after the cycle that presents the check byte, with error_detected = 0, single_error = 0, err_byte_idx = 0 and err_bit_idx = 0.
- R3: A character byte is bits [6:0] of the text code plus a parity bit in bit 7; it passes row parity only if its 8 bits hold an odd number of ones.
- R4: The check byte is byte index DATA_BYTES (12 by default); its bit j must make the number of ones in bit position j over all character bytes plus the check byte odd. A check byte built with even column parity makes every column fail and gives error_detected = 1, single_error = 0.
- R5: When exactly one bit of one character byte is flipped, the verdict is error_detected = 1, single_error = 1, err_byte_idx = the 0-based arrival position of that byte and err_bit_idx = the flipped bit position (0 = least significant, 7 = parity bit).
- R6: When exactly one bit of the check byte is flipped, the verdict is error_detected = 1, single_error = 1, err_byte_idx = DATA_BYTES (12) and err_bit_idx = the flipped bit position.
- R7: Any other failure pattern (two or more failing rows, two or more failing columns, or failing rows with no failing column) gives error_detected = 1, single_error = 0, err_byte_idx = 0, err_bit_idx = 0.
- R8: done is high for exactly one clock per frame, and the verdict outputs keep their values from that cycle until a start_of_frame is accepted.
- R9: A start_of_frame pulse restarts the frame at any time, including mid-frame: the byte count, column accumulator and row-failure record are cleared, the verdict outputs read 0 in the following cycle, and a byte presented in the same cycle as start_of_frame is character index 0 of the new frame.
- R10: Bytes presented after the check byte and before the next start_of_frame are ignored: no done pulse is produced and the verdict outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_of_frame | input | 1 | Restarts frame collection; a byte in the same cycle is index 0 |
| byte_valid | input | 1 | byte_in holds a byte to take this cycle |
| byte_in | input | 8 | Character byte (parity in bit 7) or the trailing check byte |
| done | output | 1 | One-cycle pulse after the check byte is taken |
| error_detected | output | 1 | Frame contained at least one parity failure |
| single_error | output | 1 | Failure pattern locates exactly one flipped bit |
| err_byte_idx | output | 4 | Index of the byte holding the located bit; 12 means the check byte |
| err_bit_idx | output | 3 | Bit position of the located flip |

## Verification
The bench builds the block with its default parameters, 12 character bytes of 8 bits, so the byte index uses its full 4-bit range and the check-byte code 12 sits directly above the last character index 11. That reach lets the directed tasks place single flips at the first and last character, in the parity bit and in the check byte, and lets them mix row-only, column-only and multi-row patterns against the same 12-character message. Mid-frame restarts and trailing bytes after the check byte are driven so that a stale count or a stale failure record would change the reported location.

// File: rtl/parity_locator_pkg.sv
package parity_locator_pkg;

  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_HOLD    = 1'b1
  } phase_t;

  typedef enum logic [1:0] {
    ROW_NONE = 2'd0,
    ROW_ONE  = 2'd1,
    ROW_MANY = 2'd2
  } row_tally_t;

endpackage

// File: rtl/plc_row_parity.sv
module plc_row_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  output logic         odd_ok
);
  // odd-parity row test: an odd count of ones passes (R3)
  always_comb begin
    odd_ok = 1'b0;
    for (int i = 0; i < W; i++) begin
      odd_ok = odd_ok ^ data[i];
    end
  end
endmodule

// File: rtl/plc_column_acc.sv
module plc_column_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         take,
  input  logic [W-1:0] data,
  output logic [W-1:0] acc_next
);
  logic [W-1:0] acc_q;
  logic         acc_en;

  always_comb begin
    acc_next = (clear ? '0 : acc_q) ^ (take ? data : '0);
    acc_en   = clear | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/plc_frame_ctrl.sv
module plc_frame_ctrl
  import parity_locator_pkg::*;
#(
  parameter int DATA_BYTES = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             byte_valid,
  input  logic             row_bad,
  output logic             data_take,
  output logic             check_take,
  output row_tally_t       tally,
  output logic [IDX_W-1:0] first_bad
);
  localparam logic [IDX_W-1:0] CHK_IDX = IDX_W'(DATA_BYTES);

  phase_t           phase_q, phase_d, phase_base;
  logic [IDX_W-1:0] cnt_q, cnt_d, cnt_base;
  row_tally_t       tally_q, tally_d, tally_base;
  logic [IDX_W-1:0] first_q, first_d, first_base;
  logic             take, ctrl_en;

  always_comb begin
    phase_base = frame_start ? PH_COLLECT : phase_q;
    cnt_base   = frame_start ? '0 : cnt_q;
    tally_base = frame_start ? ROW_NONE : tally_q;
    first_base = frame_start ? '0 : first_q;

    take       = byte_valid && (phase_base == PH_COLLECT);
    data_take  = take && (cnt_base != CHK_IDX);
    check_take = take && (cnt_base == CHK_IDX);
    ctrl_en    = frame_start | take;

    phase_d = phase_base;
    cnt_d   = cnt_base;
    tally_d = tally_base;
    first_d = first_base;
    if (data_take) begin
      cnt_d = cnt_base + IDX_W'(1);
      if (row_bad) begin
        case (tally_base)
          ROW_NONE: begin
            tally_d = ROW_ONE;
            first_d = cnt_base;
          end
          default: tally_d = ROW_MANY;
        endcase
      end
    end
    if (check_take) begin
      phase_d = PH_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_COLLECT;
      cnt_q   <= '0;
      tally_q <= ROW_NONE;
      first_q <= '0;
    end else if (ctrl_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tally_q <= tally_d;
      first_q <= first_d;
    end
  end

  assign tally     = tally_q;
  assign first_bad = first_q;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CHK_IDX);

  assert_hold_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && !frame_start) |=> (phase_q == PH_HOLD) && $stable(cnt_q));

  assert_tally_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tally_q == ROW_MANY && !frame_start) |=> (tally_q == ROW_MANY));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !byte_valid) |=> (cnt_q == '0) && (tally_q == ROW_NONE));
endmodule

// File: rtl/plc_verdict.sv
module plc_verdict
  import parity_locator_pkg::*;
#(
  parameter int W          = 8,
  parameter int DATA_BYTES = 12,
  parameter int IDX_W      = 4,
  parameter int BIT_W      = 3
) (
  input  logic [W-1:0]     col_sum,
  input  row_tally_t       tally,
  input  logic [IDX_W-1:0] first_bad,
  output logic             detected,
  output logic             single,
  output logic [IDX_W-1:0] byte_idx,
  output logic [BIT_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] CHK_IDX = IDX_W'(DATA_BYTES);

  logic [W-1:0]     col_fail;
  logic             no_col, one_col;
  logic [BIT_W-1:0] col_pos;

  // a column passes when its overall xor is 1 (odd count)
  assign col_fail = ~col_sum;

  always_comb begin
    col_pos = '0;
    for (int j = 0; j < W; j++) begin
      if (col_fail[j]) col_pos = BIT_W'(j);
    end
    no_col  = (col_fail == '0);
    one_col = $onehot(col_fail);

    detected = 1'b1;
    single   = 1'b0;
    byte_idx = '0;
    bit_idx  = '0;
    if (no_col && tally == ROW_NONE) begin
      detected = 1'b0;
    end else if (one_col && tally == ROW_ONE) begin
      single   = 1'b1;
      byte_idx = first_bad;
      bit_idx  = col_pos;
    end else if (one_col && tally == ROW_NONE) begin
      single   = 1'b1;
      byte_idx = CHK_IDX;
      bit_idx  = col_pos;
    end
  end
endmodule

// File: rtl/parity_locator.sv
module parity_locator
  import parity_locator_pkg::*;
#(
  parameter int DATA_BYTES = 12,
  parameter int BYTE_W     = 8,
  localparam int IDX_W     = $clog2(DATA_BYTES + 1),
  localparam int BIT_W     = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_of_frame,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              done,
  output logic              error_detected,
  output logic              single_error,
  output logic [IDX_W-1:0]  err_byte_idx,
  output logic [BIT_W-1:0]  err_bit_idx
);
  localparam logic [IDX_W-1:0] CHK_IDX = IDX_W'(DATA_BYTES);

  logic              row_ok, data_take, check_take;
  row_tally_t        tally;
  logic [IDX_W-1:0]  first_bad;
  logic [BYTE_W-1:0] col_next;
  logic              v_det, v_single;
  logic [IDX_W-1:0]  v_byte;
  logic [BIT_W-1:0]  v_bit;
  logic              res_en;
  logic              det_d, single_d;
  logic [IDX_W-1:0]  byte_d;
  logic [BIT_W-1:0]  bit_d;

  plc_row_parity #(.W(BYTE_W)) u_row (
    .data   (byte_in),
    .odd_ok (row_ok)
  );

  plc_frame_ctrl #(.DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (start_of_frame),
    .byte_valid  (byte_valid),
    .row_bad     (~row_ok),
    .data_take   (data_take),
    .check_take  (check_take),
    .tally       (tally),
    .first_bad   (first_bad)
  );

  plc_column_acc #(.W(BYTE_W)) u_cols (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_of_frame),
    .take     (data_take | check_take),
    .data     (byte_in),
    .acc_next (col_next)
  );

  plc_verdict #(.W(BYTE_W), .DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_verdict (
    .col_sum   (col_next),
    .tally     (tally),
    .first_bad (first_bad),
    .detected  (v_det),
    .single    (v_single),
    .byte_idx  (v_byte),
    .bit_idx   (v_bit)
  );

  always_comb begin
    res_en   = check_take | start_of_frame;
    det_d    = check_take ? v_det    : 1'b0;
    single_d = check_take ? v_single : 1'b0;
    byte_d   = check_take ? v_byte   : '0;
    bit_d    = check_take ? v_bit    : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= check_take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error_detected <= 1'b0;
      single_error   <= 1'b0;
      err_byte_idx   <= '0;
      err_bit_idx    <= '0;
    end else if (res_en) begin
      error_detected <= det_d;
      single_error   <= single_d;
      err_byte_idx   <= byte_d;
      err_bit_idx    <= bit_d;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_single_implies_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    single_error |-> error_detected);

  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    single_error |-> (err_byte_idx <= CHK_IDX));

  assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_of_frame && !check_take) |=>
      $stable({error_detected, single_error, err_byte_idx, err_bit_idx}));

  assert_restart_clears_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_of_frame && !check_take) |=> (!error_detected && !single_error && !done));

  assert_clean_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!error_detected) |-> (!single_error && err_byte_idx == '0 && err_bit_idx == '0));
endmodule

// File: tb/parity_locator_bench.sv
module parity_locator_bench;
  localparam int NB = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_of_frame;
  logic       byte_valid;
  logic [7:0] byte_in;
  logic       done;
  logic       error_detected;
  logic       single_error;
  logic [3:0] err_byte_idx;
  logic [2:0] err_bit_idx;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] golden [NB+1];
  logic [7:0] frm    [NB+1];

  always #2.5 clk = ~clk;

  parity_locator u_parity_locator (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_of_frame (start_of_frame),
    .byte_valid     (byte_valid),
    .byte_in        (byte_in),
    .done           (done),
    .error_detected (error_detected),
    .single_error   (single_error),
    .err_byte_idx   (err_byte_idx),
    .err_bit_idx    (err_bit_idx)
  );

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_verdict(string tag, int det, int sgl, int bidx, int bitx);
    expect_eq({tag, " error_detected"}, int'(error_detected), det);
    expect_eq({tag, " single_error"},   int'(single_error),   sgl);
    expect_eq({tag, " err_byte_idx"},   int'(err_byte_idx),   bidx);
    expect_eq({tag, " err_bit_idx"},    int'(err_bit_idx),    bitx);
  endtask

  // build odd-parity characters and an odd column check byte (R3, R4)
  task automatic build_golden();
    string msg = "PARITY CHECK";
    logic [7:0] cols = 8'h00;
    for (int i = 0; i < NB; i++) begin
      logic [6:0] ch = msg[i][6:0];
      golden[i] = {~(^ch), ch};
      cols = cols ^ golden[i];
    end
    golden[NB] = ~cols;
  endtask

  task automatic reload();
    for (int i = 0; i <= NB; i++) frm[i] = golden[i];
  endtask

  task automatic flip(int idx, int bitpos);
    frm[idx][bitpos] = ~frm[idx][bitpos];
  endtask

  // sends frm with start_of_frame on byte 0, then checks the done cycle
  // and one hold cycle against the expected verdict
  task automatic run_frame(string tag, int det, int sgl, int bidx, int bitx);
    for (int i = 0; i <= NB; i++) begin
      @(negedge clk);
      start_of_frame = (i == 0);
      byte_valid     = 1'b1;
      byte_in        = frm[i];
    end
    @(negedge clk);
    start_of_frame = 1'b0;
    byte_valid     = 1'b0;
    expect_eq({tag, " done pulse R8"}, int'(done), 1);
    expect_verdict(tag, det, sgl, bidx, bitx);
    @(negedge clk);
    expect_eq({tag, " done low R8"}, int'(done), 0);
    expect_verdict({tag, " hold R8"}, det, sgl, bidx, bitx);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start_of_frame = 1'b0;
    byte_valid = 1'b0;
    byte_in = 8'h00;
    repeat (3) @(negedge clk);
    expect_eq("R1 done in reset", int'(done), 0);
    expect_verdict("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_verdict("R1 after reset", 0, 0, 0, 0);
    // first frame after reset without start_of_frame: byte 0 is index 0
    reload();
    flip(0, 4);
    for (int i = 0; i <= NB; i++) begin
      byte_valid = 1'b1;
      byte_in    = frm[i];
      @(negedge clk);
    end
    byte_valid = 1'b0;
    expect_eq("R1 done first frame", int'(done), 1);
    expect_verdict("R1 first frame index", 1, 1, 0, 4);
  endtask

  task automatic t_clean();
    reload();
    run_frame("R2 clean", 0, 0, 0, 0);
  endtask

  task automatic t_single_data();
    reload(); flip(5, 3);
    run_frame("R5 byte5 bit3", 1, 1, 5, 3);
    reload(); flip(0, 7);
    run_frame("R5 R3 byte0 parity bit", 1, 1, 0, 7);
    reload(); flip(11, 0);
    run_frame("R5 byte11 bit0", 1, 1, 11, 0);
  endtask

  task automatic t_check_byte();
    reload(); flip(NB, 6);
    run_frame("R6 check byte bit6", 1, 1, 12, 6);
    reload(); flip(NB, 0);
    run_frame("R6 check byte bit0", 1, 1, 12, 0);
  endtask

  task automatic t_multi();
    reload(); flip(2, 1); flip(7, 5);
    run_frame("R7 two rows two cols", 1, 0, 0, 0);
    reload(); flip(4, 1); flip(4, 2);
    run_frame("R7 one byte two bits", 1, 0, 0, 0);
    reload(); flip(3, 2); flip(9, 2);
    run_frame("R7 two rows no col", 1, 0, 0, 0);
    reload(); frm[NB] = ~golden[NB];
    run_frame("R4 even check byte", 1, 0, 0, 0);
  endtask

  task automatic t_restart();
    // partial frame with two corrupted rows, then a restart
    reload(); flip(1, 0); flip(2, 6);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start_of_frame = (i == 0);
      byte_valid     = 1'b1;
      byte_in        = frm[i];
    end
    reload(); flip(3, 2);
    run_frame("R9 restart mid-frame", 1, 1, 3, 2);
    // bare start_of_frame clears held verdict
    @(negedge clk);
    start_of_frame = 1'b1;
    @(negedge clk);
    start_of_frame = 1'b0;
    expect_eq("R9 sof clears done", int'(done), 0);
    expect_verdict("R9 sof clears", 0, 0, 0, 0);
  endtask

  task automatic t_trailing();
    reload(); flip(8, 5);
    run_frame("R10 setup", 1, 1, 8, 5);
    reload();
    for (int i = 0; i <= NB; i++) begin
      byte_valid = 1'b1;
      byte_in    = frm[i];
      @(negedge clk);
      if (done) expect_eq("R10 no done on trailing", int'(done), 0);
    end
    byte_valid = 1'b0;
    @(negedge clk);
    expect_eq("R10 no done after trailing", int'(done), 0);
    expect_verdict("R10 verdict kept", 1, 1, 8, 5);
  endtask

  initial begin
    build_golden();
    t_reset();
    t_clean();
    t_single_data();
    t_check_byte();
    t_multi();
    t_restart();
    t_trailing();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule